// File: doc/BRIEF.md
# TDM Frame Sync Generator

This block produces the frame timing for a multi-slot time-division audio port. It advances once per bit clock, marked by a one-cycle `bclk_en` strobe in the system clock domain. It reports where the current bit clock falls in the frame: the slot number, the bit number inside that slot, and whether the bit belongs to an active slot or to the idle padding at the end of the frame.

In master mode the block counts the frame on its own and drives a frame-sync output. The sync is either a single bit clock wide or a full slot wide. A single-bit sync can land on the first bit of slot 0 or one bit clock ahead of it. In slave mode the block leaves its sync output low and takes its frame position from the rising edge of an external sync input.

A combinational legality check compares the programmed divider with the slot length and the slot count. While the check fails, the block holds its timing idle and raises an error flag.

Top module: `tdm_frame_timer`

## Requirements
- R1: While `enable` is low, no frame timing is produced: `fs_out` and `active` are 0 and the position does not advance.
- R2: In master mode, once enabled with a legal configuration, the first `bclk_en` strobe is position 0. The frame then repeats every `frame_div`+1 strobes, so position `frame_div` is followed by position 0.
- R3: `slot_len_code` selects the slot length: 0 is 8 bits, 1 is 16 bits and 2 is 32 bits. Code 3 is reserved and raises `cfg_err`. `slot_idx` is the position divided by the slot length and `bit_idx` is the remainder.
- R4: With `long_sync`=0 and `early_align`=0, the master `fs_out` is high only at position 0, the first bit of slot 0.
- R5: With `long_sync`=0 and `early_align`=1, the master `fs_out` is high only at position `frame_div`, one bit clock before the first bit of slot 0.
- R6: With `long_sync`=1, the master `fs_out` is high for positions 0 to slot length−1, and `early_align` has no effect.
- R7: `cfg_err` is 1 when `frame_div`+1 is less than the slot length times `slot_count`.
- R8: `cfg_err` is 1 when `long_sync`=1, `slot_count` ≤ 1 and `frame_div`+1 ≤ the slot length. With `long_sync`=0 the same settings are legal unless R7 applies.
- R9: While `cfg_err` is 1, `fs_out` and `active` are 0.
- R10: With `slave_mode`=1, `fs_out` stays 0. A strobe that samples `fs_in` high after it was low restarts the frame. The restart lands at position 0 for a late or long sync. For an early short sync it lands at position `frame_div`, so that the next strobe is position 0. Between rising edges the position wraps as in R2.
- R11: Positions at or beyond the slot length times `slot_count` are padding: `active` is 0 and `slot_idx` and `bit_idx` read 0.
- R12: Between `bclk_en` strobes, with the configuration unchanged, all timing outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_en | input | 1 | One-cycle strobe per bit clock |
| enable | input | 1 | Global enable for frame timing |
| slave_mode | input | 1 | 0 = master (drives sync), 1 = slave (follows `fs_in`) |
| long_sync | input | 1 | 0 = one-bit sync, 1 = slot-wide sync |
| early_align | input | 1 | 1 = short sync one bit before slot 0 |
| frame_div | input | DIV_W | Frame length in bit clocks minus one |
| slot_len_code | input | 2 | Slot length selector |
| slot_count | input | CNT_W | Number of active slots |
| fs_in | input | 1 | External frame sync in slave mode |
| fs_out | output | 1 | Generated frame sync |
| active | output | 1 | Current bit lies in an active slot |
| slot_idx | output | DIV_W-3 | Current slot number |
| bit_idx | output | 5 | Bit number inside the slot |
| cfg_err | output | 1 | Configuration is illegal |

## Verification
The bench works through the legality boundaries on both sides. It uses a divider exactly one short of slot length times slot count, and the single-slot long-sync case with the frame equal to one slot (illegal) and one bit longer (legal). A design with an off-by-one in either comparison would flag a legal setup or pass an illegal one. The bench also runs an early short sync in master and in slave mode. A design that put the pulse on bit 0, or restarted the slave at position 0, would be misaligned by one bit clock. The long-sync run sets `early_align` and has padding bits at the end of the frame. This catches a design that lets the alignment bit shorten the slot-wide pulse, or one that reports slot numbers in the idle tail. In slave mode a second rising sync arrives in mid-frame; a design that ignores it keeps counting from the stale position.

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int DIV_W = 10,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_en,
  input  logic             enable,
  input  logic             slave_mode,
  input  logic             long_sync,
  input  logic             early_align,
  input  logic [DIV_W-1:0] frame_div,
  input  logic [1:0]       slot_len_code,
  input  logic [CNT_W-1:0] slot_count,
  input  logic             fs_in,
  output logic             fs_out,
  output logic             active,
  output logic [DIV_W-4:0] slot_idx,
  output logic [4:0]       bit_idx,
  output logic             cfg_err
);

  localparam int NW = DIV_W + CNT_W + 7;

  logic [DIV_W-1:0] pos;
  logic             run;
  logic             fs_d;
  logic [5:0]       slen;
  logic [NW-1:0]    need;
  logic [NW-1:0]    flen;
  logic             ok;
  logic             rise;
  logic [DIV_W-1:0] pos_next;
  logic [DIV_W-1:0] slot_full;
  logic             sync_hit;

  assign slen = (slot_len_code == 2'd0) ? 6'd8 :
                (slot_len_code == 2'd1) ? 6'd16 : 6'd32;
  assign need = NW'(slen) * NW'(slot_count);
  assign flen = NW'(frame_div) + NW'(1);

  assign cfg_err = (slot_len_code == 2'd3) || (flen < need) ||
                   (long_sync && (slot_count <= CNT_W'(1)) && (flen <= NW'(slen)));

  assign ok       = enable && !cfg_err;
  assign rise     = fs_in && !fs_d;
  assign pos_next = (pos == frame_div) ? '0 : pos + DIV_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      pos  <= '0;
      fs_d <= 1'b0;
    end else if (!ok) begin
      run  <= 1'b0;
      pos  <= '0;
      fs_d <= 1'b0;
    end else if (bclk_en) begin
      fs_d <= fs_in;
      if (slave_mode) begin
        if (rise) begin
          run <= 1'b1;
          pos <= (early_align && !long_sync) ? frame_div : '0;
        end else if (run) begin
          pos <= pos_next;
        end
      end else if (!run) begin
        run <= 1'b1;
        pos <= '0;
      end else begin
        pos <= pos_next;
      end
    end
  end

  always_comb begin
    if (long_sync)        sync_hit = NW'(pos) < NW'(slen);
    else if (early_align) sync_hit = (pos == frame_div);
    else                  sync_hit = (pos == '0);
  end

  always_comb begin
    case (slot_len_code)
      2'd0:    slot_full = pos >> 3;
      2'd1:    slot_full = pos >> 4;
      default: slot_full = pos >> 5;
    endcase
  end

  assign fs_out   = run && ok && !slave_mode && sync_hit;
  assign active   = run && ok && (NW'(pos) < need);
  assign slot_idx = active ? slot_full[DIV_W-4:0] : '0;
  assign bit_idx  = active ? (pos[4:0] & 5'(slen - 6'd1)) : '0;

endmodule

// File: rtl/tdm_frame_timer_chk.sv
module tdm_frame_timer_chk #(
  parameter int DIV_W = 10,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bclk_en,
  input logic             enable,
  input logic             slave_mode,
  input logic             long_sync,
  input logic             early_align,
  input logic [DIV_W-1:0] frame_div,
  input logic             fs_out,
  input logic             active,
  input logic [DIV_W-4:0] slot_idx,
  input logic [4:0]       bit_idx,
  input logic             cfg_err,
  input logic [DIV_W-1:0] pos,
  input logic             run
);

  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!fs_out && !active));

  a_r9_err_no_sync: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!fs_out && !active));

  a_r10_slave_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> !fs_out);

  a_r11_padding_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (slot_idx == '0 && bit_idx == '0));

  a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && enable && !cfg_err && !slave_mode && bclk_en && pos == frame_div) |=> (pos == '0));

  a_r12_hold_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !cfg_err && !bclk_en) |=> $stable(pos));

  a_r4_short_single: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_out && !long_sync && bclk_en && frame_div != '0) |=>
      (!fs_out || !$stable(frame_div) || !$stable(long_sync) ||
       !$stable(early_align) || !$stable(slave_mode) || !$stable(enable)));

endmodule

bind tdm_frame_timer tdm_frame_timer_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .enable(enable),
  .slave_mode(slave_mode), .long_sync(long_sync), .early_align(early_align),
  .frame_div(frame_div), .fs_out(fs_out), .active(active),
  .slot_idx(slot_idx), .bit_idx(bit_idx), .cfg_err(cfg_err),
  .pos(pos), .run(run)
);

// File: tb/tdm_frame_timer_bench.sv
module tdm_frame_timer_bench;
  localparam int DIV_W = 10;
  localparam int CNT_W = 4;
  localparam int CLK_NS = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk_en = 1'b0, enable = 1'b0, slave_mode = 1'b0, long_sync = 1'b0;
  logic early_align = 1'b0, fs_in = 1'b0;
  logic [DIV_W-1:0] frame_div = 10'd63;
  logic [1:0] slot_len_code = 2'd1;
  logic [CNT_W-1:0] slot_count = 4'd4;
  logic fs_out, active, cfg_err;
  logic [DIV_W-4:0] slot_idx;
  logic [4:0] bit_idx;

  always #(CLK_NS/2) clk = ~clk;

  tdm_frame_timer #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_tdm_frame_timer (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .enable(enable),
    .slave_mode(slave_mode), .long_sync(long_sync), .early_align(early_align),
    .frame_div(frame_div), .slot_len_code(slot_len_code), .slot_count(slot_count),
    .fs_in(fs_in), .fs_out(fs_out), .active(active), .slot_idx(slot_idx),
    .bit_idx(bit_idx), .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic       fs;
    logic       act;
    logic [6:0] slot;
    logic [4:0] bitn;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  exp_t  cur;
  string cur_tag;
  logic  hold_ok = 1'b0;
  logic  tick_seen = 1'b0;
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;

  int m_run = 0, m_pos = 0, m_prev = 0;

  always @(posedge clk) tick_seen <= bclk_en;

  function automatic int slen_of(input int code);
    return (code == 0) ? 8 : (code == 1) ? 16 : 32;
  endfunction

  function automatic bit model_err();
    int sl = slen_of(int'(slot_len_code));
    int fl = int'(frame_div) + 1;
    if (slot_len_code == 2'd3) return 1;
    if (fl < sl * int'(slot_count)) return 1;
    if (long_sync && slot_count <= 1 && fl <= sl) return 1;
    return 0;
  endfunction

  function automatic exp_t model_out();
    exp_t e;
    int sl = slen_of(int'(slot_len_code));
    bit err = model_err();
    bit run_ok = (m_run != 0) && enable && !err;
    bit hit;
    if (long_sync) hit = m_pos < sl;
    else if (early_align) hit = (m_pos == int'(frame_div));
    else hit = (m_pos == 0);
    e.fs   = run_ok && !slave_mode && hit;
    e.act  = run_ok && (m_pos < sl * int'(slot_count));
    e.slot = e.act ? 7'(m_pos / sl) : 7'd0;
    e.bitn = e.act ? 5'(m_pos % sl) : 5'd0;
    return e;
  endfunction

  task automatic model_step(input logic fsi);
    if (!enable || model_err()) begin
      m_run = 0; m_pos = 0; m_prev = 0;
    end else if (slave_mode) begin
      if (fsi && m_prev == 0) begin
        m_run = 1;
        m_pos = (early_align && !long_sync) ? int'(frame_div) : 0;
      end else if (m_run != 0) begin
        m_pos = (m_pos == int'(frame_div)) ? 0 : m_pos + 1;
      end
      m_prev = int'(fsi);
    end else if (m_run == 0) begin
      m_run = 1; m_pos = 0;
    end else begin
      m_pos = (m_pos == int'(frame_div)) ? 0 : m_pos + 1;
    end
  endtask

  task automatic check(input bit okc, input string tag, input string what,
                       input int act_v, input int exp_v);
    n_chk++;
    if (!okc) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act_v, exp_v);
    end
  endtask

  task automatic compare(input exp_t e, input string tag);
    exp_t a;
    a.fs = fs_out; a.act = active; a.slot = slot_idx; a.bitn = bit_idx;
    check(a == e, tag, "fs/active/slot/bit", int'(a), int'(e));
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (tick_seen) begin
        if (q.size() == 0) begin
          check(0, "R2", "scoreboard underflow", 0, 1);
        end else begin
          cur = q.pop_front();
          cur_tag = tq.pop_front();
          compare(cur, cur_tag);
          hold_ok = 1'b1;
        end
      end else if (hold_ok) begin
        compare(cur, "R12");
      end
    end
  end

  task automatic tick(input logic fsi, input string tag);
    fs_in = fsi;
    bclk_en = 1'b1;
    model_step(fsi);
    q.push_back(model_out());
    tq.push_back(tag);
    @(posedge clk); #1;
    bclk_en = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic apply_cfg(input logic sl_m, input logic lg, input logic ea,
                           input int div, input int code, input int cnt);
    hold_ok = 1'b0;
    enable = 1'b0;
    fs_in = 1'b0;
    @(posedge clk); #1;
    slave_mode = sl_m; long_sync = lg; early_align = ea;
    frame_div = DIV_W'(div); slot_len_code = 2'(code); slot_count = CNT_W'(cnt);
    m_run = 0; m_pos = 0; m_prev = 0;
    @(posedge clk); #1;
    enable = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic err_case(input logic lg, input int div, input int code,
                          input int cnt, input bit exp_e, input string tag);
    apply_cfg(1'b0, lg, 1'b0, div, code, cnt);
    check(cfg_err == exp_e, tag, "cfg_err", int'(cfg_err), int'(exp_e));
    tick(1'b0, tag);
    tick(1'b0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!fs_out && !active, "R1", "reset outputs", int'({fs_out, active}), 0);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: disabled, strobes produce nothing
    for (int i = 0; i < 4; i++) tick(1'b0, "R1");

    // R4/R2/R3: master short late, 16-bit slots, 4 slots, 64-bit frame
    apply_cfg(1'b0, 1'b0, 1'b0, 63, 1, 4);
    for (int i = 0; i < 130; i++) tick(1'b0, "R4");

    // R5/R3: master short early, 8-bit slots, 4 slots, 32-bit frame
    apply_cfg(1'b0, 1'b0, 1'b1, 31, 0, 4);
    for (int i = 0; i < 70; i++) tick(1'b0, "R5");

    // R6/R11: long sync with early_align set, 32-bit slot, padding tail
    apply_cfg(1'b0, 1'b1, 1'b1, 47, 2, 1);
    for (int i = 0; i < 100; i++) tick(1'b0, "R6");

    // R11: 8-bit slots, 3 slots in a 40-bit frame
    apply_cfg(1'b0, 1'b0, 1'b0, 39, 0, 3);
    for (int i = 0; i < 84; i++) tick(1'b0, "R11");

    // R7/R8/R3/R9: legality boundaries
    err_case(1'b0, 62, 1, 4, 1, "R7");
    err_case(1'b0, 63, 1, 4, 0, "R7");
    err_case(1'b1, 7, 0, 1, 1, "R8");
    err_case(1'b0, 7, 0, 1, 0, "R8");
    err_case(1'b1, 8, 0, 1, 0, "R8");
    err_case(1'b1, 15, 1, 0, 1, "R8");
    err_case(1'b0, 63, 3, 1, 1, "R3");
    err_case(1'b1, 31, 0, 1, 0, "R9");

    // R10: slave, short late
    apply_cfg(1'b1, 1'b0, 1'b0, 15, 0, 2);
    for (int i = 0; i < 3; i++) tick(1'b0, "R10");
    tick(1'b1, "R10");
    for (int i = 0; i < 20; i++) tick(1'b0, "R10");
    tick(1'b1, "R10");
    for (int i = 0; i < 10; i++) tick(1'b0, "R10");

    // R10: slave, short early
    apply_cfg(1'b1, 1'b0, 1'b1, 15, 0, 2);
    tick(1'b0, "R10");
    tick(1'b1, "R10");
    for (int i = 0; i < 20; i++) tick(1'b0, "R10");

    // R10: slave, long sync held high for a slot
    apply_cfg(1'b1, 1'b1, 1'b0, 15, 0, 1);
    for (int i = 0; i < 8; i++) tick(1'b1, "R10");
    for (int i = 0; i < 24; i++) tick(1'b0, "R10");

    // R1: disable mid-frame
    apply_cfg(1'b0, 1'b0, 1'b0, 15, 0, 2);
    for (int i = 0; i < 5; i++) tick(1'b0, "R1");
    hold_ok = 1'b0;
    enable = 1'b0;
    @(posedge clk); #1;
    for (int i = 0; i < 4; i++) tick(1'b0, "R1");

    repeat (4) @(posedge clk);
    check(q.size() == 0, "R2", "scoreboard drained", q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule